// File: doc/BRIEF.md
# Cell Interface Loopback Controller

This block sits between a segmentation engine, a reassembly engine and the physical-layer cell interfaces. A host writes a small configuration register to start a software reset, to turn loopback on, and to turn the transmit and receive engines on. In normal operation the segmentation cell stream goes out to the PHY, and the PHY receive stream goes to the reassembly engine. In loopback the segmentation stream is turned back into the reassembly input. The PHY transmit outputs are held at zero, and the PHY receive inputs are not used.

Loopback may only be entered in a fixed order. First a software reset must complete. Then a write sets the loop bit. Then a later write sets the enable bits. Writes that break this order are refused and raise a sticky sequence-error flag. Once loopback has been left, only a software reset makes the register writable again.

The receive-side interface clock comes from a glitch-free clock selector. This lets the reassembly logic run from the transmit-side clock during loopback, even when the two external clocks are asynchronous to each other.

Top module: `cell_loopback_ctrl`

## Requirements
- R1: While loopback is on, phy_tx_data, phy_tx_soc and phy_tx_valid are all zero. Otherwise they equal seg_data, seg_soc and seg_valid.
- R2: While loopback is on, rsm_data, rsm_soc and rsm_valid equal the seg_* inputs, and the phy_rx_* inputs have no effect. Otherwise they equal phy_rx_*.
- R3: A write with wr_data bit 0 set (soft reset) makes busy read one for exactly RST_CYC (default 10) host cycles. It clears loop_on, tx_en, rx_en and seq_err.
- R4: While busy is one, every host write is ignored.
- R5: A write with wr_data bit 1 set (loop) enters loopback only if a soft reset has completed since the hard reset or since the last entry into loopback. Otherwise the write leaves all control outputs unchanged and sets seq_err.
- R6: A write that enters loopback together with bit 2 (transmit enable) or bit 3 (receive enable) set leaves tx_en and rx_en clear and sets seq_err. In loopback, a later write with bit 1 still set loads tx_en from bit 2 and rx_en from bit 3.
- R7: In loopback, a write with bit 1 clear leaves loopback and clears tx_en and rx_en. After that, every write other than a soft reset is ignored until a soft reset completes.
- R8: Outside loopback, with no exit pending, a write with bit 1 clear loads tx_en from bit 2 and rx_en from bit 3.
- R9: rx_clk_out follows rx_clk_ext outside loopback and follows tx_clk once the changeover has settled in loopback. The two clock gates are never open at the same time.
- R10: After hard reset, busy, loop_on, tx_en, rx_en and seq_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host register clock |
| rst_n | input | 1 | Synchronous active-low hard reset, held for several cycles of every clock |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 4 | Write value: bit 0 soft reset, bit 1 loop, bit 2 transmit enable, bit 3 receive enable |
| busy | output | 1 | Soft reset in progress |
| seq_err | output | 1 | Sticky write-order error |
| loop_on | output | 1 | Loopback active |
| tx_en | output | 1 | Transmit engine enable |
| rx_en | output | 1 | Receive engine enable |
| tx_clk | input | 1 | Segmentation-side interface clock |
| rx_clk_ext | input | 1 | External reassembly-side interface clock |
| rx_clk_out | output | 1 | Selected reassembly-side clock |
| seg_data | input | DATA_W | Cell byte from segmentation engine |
| seg_soc | input | 1 | Start of cell from segmentation engine |
| seg_valid | input | 1 | Byte valid from segmentation engine |
| phy_tx_data | output | DATA_W | Cell byte to PHY |
| phy_tx_soc | output | 1 | Start of cell to PHY |
| phy_tx_valid | output | 1 | Byte valid to PHY |
| phy_rx_data | input | DATA_W | Cell byte from PHY |
| phy_rx_soc | input | 1 | Start of cell from PHY |
| phy_rx_valid | input | 1 | Byte valid from PHY |
| rsm_data | output | DATA_W | Cell byte to reassembly engine |
| rsm_soc | output | 1 | Start of cell to reassembly engine |
| rsm_valid | output | 1 | Byte valid to reassembly engine |

## Verification
The cell path is swept over all 256 byte values in both modes. The PHY receive input is driven with the inverse of the segmentation byte, so a wrong source selection shows up on every bit, and the start and valid flags take different bits of the sweep value. All four enable combinations are written in normal mode. The write order is then tried in each of its wrong forms: loop before any soft reset, loop and enable in one write, writes during the busy window, and writes after a loopback exit. Each of these is told apart from the legal order by the control outputs. The selected receive clock is sampled in both phases of each candidate clock, before, during and after loopback.

// File: rtl/lbk_pkg.sv
// Package: shared field positions and the control mode type for the
// loopback controller. Assumes a four-bit host write word.
package lbk_pkg;
    localparam int CFG_W  = 4;
    localparam int F_SRST = 0;
    localparam int F_LOOP = 1;
    localparam int F_TXEN = 2;
    localparam int F_RXEN = 3;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_LOOP   = 2'd1,
        MODE_HOLD   = 2'd2
    } lbk_mode_e;
endpackage

// File: rtl/lbk_cfg_reg.sv
// Configuration register with soft-reset counter and write-order checks.
// Assumes one write per wr_en pulse in the clk domain.
module lbk_cfg_reg
    import lbk_pkg::*;
#(
    parameter int RST_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             busy,
    output logic             loop_on,
    output logic             tx_en,
    output logic             rx_en,
    output logic             seq_err
);
    localparam int CNT_W = $clog2(RST_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    lbk_mode_e        mode_q;
    logic             armed_q;
    logic             txen_q, rxen_q, err_q;
    logic             req_en;

    // Either enable bit requested by the current write
    assign req_en = wr_data[F_TXEN] | wr_data[F_RXEN];

    // Register update: soft reset countdown, then write-order rules
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mode_q  <= MODE_NORMAL;
            armed_q <= 1'b0;
            txen_q  <= 1'b0;
            rxen_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) armed_q <= 1'b1;
        end else if (wr_en) begin
            if (wr_data[F_SRST]) begin
                cnt_q   <= CNT_W'(RST_CYC);
                mode_q  <= MODE_NORMAL;
                armed_q <= 1'b0;
                txen_q  <= 1'b0;
                rxen_q  <= 1'b0;
                err_q   <= 1'b0;
            end else begin
                case (mode_q)
                    MODE_NORMAL: begin
                        if (wr_data[F_LOOP]) begin
                            if (armed_q) begin
                                mode_q  <= MODE_LOOP;
                                armed_q <= 1'b0;
                                txen_q  <= 1'b0;
                                rxen_q  <= 1'b0;
                                if (req_en) err_q <= 1'b1;
                            end else begin
                                err_q <= 1'b1;
                            end
                        end else begin
                            txen_q <= wr_data[F_TXEN];
                            rxen_q <= wr_data[F_RXEN];
                        end
                    end
                    MODE_LOOP: begin
                        if (wr_data[F_LOOP]) begin
                            txen_q <= wr_data[F_TXEN];
                            rxen_q <= wr_data[F_RXEN];
                        end else begin
                            mode_q <= MODE_HOLD;
                            txen_q <= 1'b0;
                            rxen_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Status outputs
    assign busy    = (cnt_q != '0);
    assign loop_on = (mode_q == MODE_LOOP);
    assign tx_en   = txen_q;
    assign rx_en   = rxen_q;
    assign seq_err = err_q;
endmodule

// File: rtl/lbk_cell_path.sv
// Cell stream routing: gates the PHY transmit side and picks the
// reassembly source. Assumes loop_on is static while cells flow.
module lbk_cell_path #(
    parameter int DATA_W = 8
) (
    input  logic              loop_on,
    input  logic [DATA_W-1:0] seg_data,
    input  logic              seg_soc,
    input  logic              seg_valid,
    output logic [DATA_W-1:0] phy_tx_data,
    output logic              phy_tx_soc,
    output logic              phy_tx_valid,
    input  logic [DATA_W-1:0] phy_rx_data,
    input  logic              phy_rx_soc,
    input  logic              phy_rx_valid,
    output logic [DATA_W-1:0] rsm_data,
    output logic              rsm_soc,
    output logic              rsm_valid
);
    // Transmit side held quiet in loopback
    always_comb begin
        phy_tx_data  = loop_on ? '0   : seg_data;
        phy_tx_soc   = loop_on ? 1'b0 : seg_soc;
        phy_tx_valid = loop_on ? 1'b0 : seg_valid;
    end

    // Reassembly source: internal stream in loopback, PHY otherwise
    always_comb begin
        rsm_data  = loop_on ? seg_data  : phy_rx_data;
        rsm_soc   = loop_on ? seg_soc   : phy_rx_soc;
        rsm_valid = loop_on ? seg_valid : phy_rx_valid;
    end
endmodule

// File: rtl/lbk_clk_leg.sv
// One side of the glitch-free clock selector. The request and the other
// side's gate pass through SYNC_N flops, then a falling-edge flop opens
// the gate, so the gate moves only while its clock is low.
// Assumes SYNC_N >= 2.
module lbk_clk_leg #(
    parameter int SYNC_N = 2
) (
    input  logic leg_clk,
    input  logic rst_n,
    input  logic want,
    input  logic other_gate,
    output logic gate
);
    logic [SYNC_N-1:0] sync_q;
    logic              gate_q;

    // Synchronise the request, held off while the other side is open
    always_ff @(posedge leg_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], want & ~other_gate};
    end

    // Open or close the gate on the low phase only
    always_ff @(negedge leg_clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= sync_q[SYNC_N-1];
    end

    assign gate = gate_q;
endmodule

// File: rtl/lbk_clk_mux.sv
// Glitch-free two-input clock select built from two lbk_clk_leg
// instances. Index 0 is the external receive clock and index 1 the
// transmit clock. sel_tx may come from any domain.
module lbk_clk_mux #(
    parameter int SYNC_N = 2
) (
    input  logic rx_clk_ext,
    input  logic tx_clk,
    input  logic rst_n,
    input  logic sel_tx,
    output logic clk_out,
    output logic gate_rx,
    output logic gate_tx
);
    logic [1:0] clks, wants, gates;

    assign clks  = {tx_clk, rx_clk_ext};
    assign wants = {sel_tx, ~sel_tx};

    // One leg per clock, each held off by the other's gate
    for (genvar g = 0; g < 2; g++) begin : g_leg
        lbk_clk_leg #(.SYNC_N(SYNC_N)) u_leg (
            .leg_clk    (clks[g]),
            .rst_n      (rst_n),
            .want       (wants[g]),
            .other_gate (gates[1-g]),
            .gate       (gates[g])
        );
    end

    // AND-OR combine of the gated clocks
    assign clk_out = |(clks & gates);
    assign gate_rx = gates[0];
    assign gate_tx = gates[1];
endmodule

// File: rtl/cell_loopback_ctrl.sv
// Top: host configuration register, cell path routing and receive clock
// select for loopback testing. Assumes rst_n is held low for several
// cycles of every clock.
module cell_loopback_ctrl
    import lbk_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int RST_CYC = 10,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    output logic              busy,
    output logic              seq_err,
    output logic              loop_on,
    output logic              tx_en,
    output logic              rx_en,
    input  logic              tx_clk,
    input  logic              rx_clk_ext,
    output logic              rx_clk_out,
    input  logic [DATA_W-1:0] seg_data,
    input  logic              seg_soc,
    input  logic              seg_valid,
    output logic [DATA_W-1:0] phy_tx_data,
    output logic              phy_tx_soc,
    output logic              phy_tx_valid,
    input  logic [DATA_W-1:0] phy_rx_data,
    input  logic              phy_rx_soc,
    input  logic              phy_rx_valid,
    output logic [DATA_W-1:0] rsm_data,
    output logic              rsm_soc,
    output logic              rsm_valid
);
    logic gate_rx, gate_tx;

    // Host register and sequencing
    lbk_cfg_reg #(.RST_CYC(RST_CYC)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (busy),
        .loop_on (loop_on),
        .tx_en   (tx_en),
        .rx_en   (rx_en),
        .seq_err (seq_err)
    );

    // Cell routing and transmit gating
    lbk_cell_path #(.DATA_W(DATA_W)) u_path (
        .loop_on      (loop_on),
        .seg_data     (seg_data),
        .seg_soc      (seg_soc),
        .seg_valid    (seg_valid),
        .phy_tx_data  (phy_tx_data),
        .phy_tx_soc   (phy_tx_soc),
        .phy_tx_valid (phy_tx_valid),
        .phy_rx_data  (phy_rx_data),
        .phy_rx_soc   (phy_rx_soc),
        .phy_rx_valid (phy_rx_valid),
        .rsm_data     (rsm_data),
        .rsm_soc      (rsm_soc),
        .rsm_valid    (rsm_valid)
    );

    // Receive clock changeover
    lbk_clk_mux #(.SYNC_N(SYNC_N)) u_cks (
        .rx_clk_ext (rx_clk_ext),
        .tx_clk     (tx_clk),
        .rst_n      (rst_n),
        .sel_tx     (loop_on),
        .clk_out    (rx_clk_out),
        .gate_rx    (gate_rx),
        .gate_tx    (gate_tx)
    );
endmodule

// File: rtl/cell_loopback_chk.sv
// Checker for cell_loopback_ctrl, attached by bind. Watches control
// outputs, transmit gating and the clock gates in the host domain.
module cell_loopback_chk #(
    parameter int DATA_W  = 8,
    parameter int RST_CYC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              loop_on,
    input logic              tx_en,
    input logic              rx_en,
    input logic [DATA_W-1:0] phy_tx_data,
    input logic              phy_tx_soc,
    input logic              phy_tx_valid,
    input logic              gate_rx,
    input logic              gate_tx
);
    localparam int BC_W = $clog2(RST_CYC + 2);
    logic [BC_W-1:0] bcnt;

    // Length of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == BC_W'(RST_CYC));
    a_r3_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !loop_on && !tx_en && !rx_en);
    a_r4_busy_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(loop_on) && $stable(tx_en) && $stable(rx_en));
    a_r1_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> phy_tx_data == '0 && !phy_tx_soc && !phy_tx_valid);
    a_r6_enter_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_on) |-> !tx_en && !rx_en);
    a_r7_exit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loop_on) |-> !tx_en && !rx_en);
    a_r9_one_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gate_rx, gate_tx}));
endmodule

bind cell_loopback_ctrl cell_loopback_chk #(.DATA_W(DATA_W), .RST_CYC(RST_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .loop_on      (loop_on),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .phy_tx_data  (phy_tx_data),
    .phy_tx_soc   (phy_tx_soc),
    .phy_tx_valid (phy_tx_valid),
    .gate_rx      (gate_rx),
    .gate_tx      (gate_tx)
);

// File: tb/sim_cell_loopback_ctrl.sv
// Bench for cell_loopback_ctrl: sweeps cell values and write orders.
module sim_cell_loopback_ctrl;
    localparam int DW = 8;
    localparam int RC = 10;

    logic clk = 0, tx_clk = 0, rx_clk_ext = 0;
    logic rst_n = 0, wr_en = 0;
    logic [3:0] wr_data = '0;
    logic busy, seq_err, loop_on, tx_en, rx_en, rx_clk_out;
    logic [DW-1:0] seg_data = '0, phy_rx_data = '0, phy_tx_data, rsm_data;
    logic seg_soc = 0, seg_valid = 0, phy_rx_soc = 0, phy_rx_valid = 0;
    logic phy_tx_soc, phy_tx_valid, rsm_soc, rsm_valid;
    int nchk = 0, nerr = 0;

    always #10 clk = ~clk;
    always #7  tx_clk = ~tx_clk;
    always #17 rx_clk_ext = ~rx_clk_ext;

    cell_loopback_ctrl #(.DATA_W(DW), .RST_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .seq_err(seq_err), .loop_on(loop_on), .tx_en(tx_en), .rx_en(rx_en),
        .tx_clk(tx_clk), .rx_clk_ext(rx_clk_ext), .rx_clk_out(rx_clk_out),
        .seg_data(seg_data), .seg_soc(seg_soc), .seg_valid(seg_valid),
        .phy_tx_data(phy_tx_data), .phy_tx_soc(phy_tx_soc), .phy_tx_valid(phy_tx_valid),
        .phy_rx_data(phy_rx_data), .phy_rx_soc(phy_rx_soc), .phy_rx_valid(phy_rx_valid),
        .rsm_data(rsm_data), .rsm_soc(rsm_soc), .rsm_valid(rsm_valid));

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic soft_reset();
        wr(4'b0001); idle(RC + 1);
    endtask

    // Check rx_clk_out against one source in both phases
    task automatic clk_follow(input bit use_tx, input string tag);
        for (int i = 0; i < 8; i++) begin
            if (use_tx) @(posedge tx_clk); else @(posedge rx_clk_ext);
            #2 chk(tag, rx_clk_out, 1);
            if (use_tx) @(negedge tx_clk); else @(negedge rx_clk_ext);
            #2 chk(tag, rx_clk_out, 0);
        end
    endtask

    // Full byte sweep of the cell path; receive side gets the inverse
    task automatic path_sweep(input bit lp);
        for (int v = 0; v < 256; v++) begin
            seg_data = v[7:0]; seg_soc = v[0]; seg_valid = v[1];
            phy_rx_data = ~v[7:0]; phy_rx_soc = v[2]; phy_rx_valid = v[3];
            #1;
            chk("R1 tx data", phy_tx_data, lp ? 0 : v);
            chk("R1 tx flags", {phy_tx_soc, phy_tx_valid}, lp ? 0 : {v[0], v[1]});
            chk("R2 rsm data", rsm_data, lp ? v : 255 - v);
            chk("R2 rsm flags", {rsm_soc, rsm_valid}, lp ? {v[0], v[1]} : {v[2], v[3]});
        end
    endtask

    initial begin
        #4_000_000;
        nerr++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        idle(12); rst_n = 1; idle(2);
        // R10 hard reset state
        chk("R10 busy", busy, 0); chk("R10 loop", loop_on, 0);
        chk("R10 tx_en", tx_en, 0); chk("R10 rx_en", rx_en, 0);
        chk("R10 seq_err", seq_err, 0);
        idle(10);
        clk_follow(0, "R9 normal clock");

        // R8 all enable combinations in normal mode
        for (int v = 0; v < 4; v++) begin
            wr({v[1], v[0], 2'b00});
            chk("R8 tx_en", tx_en, v[0]); chk("R8 rx_en", rx_en, v[1]);
        end
        path_sweep(0);

        // R5 loop before any soft reset is refused
        wr(4'b0010);
        chk("R5 loop refused", loop_on, 0); chk("R5 seq_err", seq_err, 1);
        chk("R5 tx_en kept", tx_en, 1);

        // R3 busy window and R4 writes ignored while busy
        wr(4'b0001);
        for (int i = 0; i < RC; i++) begin
            chk("R3 busy high", busy, 1);
            wr_en = (i == 3); wr_data = (i == 3) ? 4'b1110 : 4'b0000;
            @(negedge clk);
            wr_en = 0;
        end
        chk("R3 busy low", busy, 0); chk("R3 seq_err cleared", seq_err, 0);
        chk("R4 write ignored tx", tx_en, 0); chk("R4 write ignored loop", loop_on, 0);

        // R6 loop and enable together
        wr(4'b0110);
        chk("R6 loop set", loop_on, 1); chk("R6 tx_en clear", tx_en, 0);
        chk("R6 seq_err", seq_err, 1);

        // R3 soft reset leaves loopback; then legal entry
        soft_reset();
        chk("R3 loop cleared", loop_on, 0); chk("R3 err cleared", seq_err, 0);
        wr(4'b0010);
        chk("R5 loop entered", loop_on, 1); chk("R6 enables clear", tx_en + rx_en, 0);
        wr(4'b1110);
        chk("R6 tx_en", tx_en, 1); chk("R6 rx_en", rx_en, 1);
        chk("R6 no err", seq_err, 0);
        path_sweep(1);
        idle(30);
        clk_follow(1, "R9 loop clock");

        // R7 exit and lock-out
        wr(4'b0100);
        chk("R7 loop left", loop_on, 0); chk("R7 tx_en clear", tx_en, 0);
        wr(4'b1100);
        chk("R7 locked tx", tx_en, 0); chk("R7 locked rx", rx_en, 0);
        wr(4'b0010);
        chk("R7 locked loop", loop_on, 0);
        idle(30);
        clk_follow(0, "R9 back to rx clock");
        soft_reset();
        wr(4'b0100);
        chk("R7 resumed tx_en", tx_en, 1); chk("R8 rx_en", rx_en, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule